// File: doc/BRIEF.md
# Structured 2:4 Sparse Dot-Product Unit

This unit computes the signed dot product of one weight row with a dense activation vector. The weights arrive in compressed 2:4 form. Each group of four logical weights is reduced to its two kept values and two 2-bit position indices. On every accepted beat the unit uses the indices to pick the two matching activations out of the four supplied, multiplies only those two pairs, and adds both products into a 32-bit signed accumulator. Each multiplier therefore covers two logical weight positions per beat, twice as many as a dense datapath with the same multiplier count. A group with fewer than two real non-zeros carries an explicit zero in the unused slot.

Two streams feed the unit, each with its own valid/ready handshake. The weight stream carries the two kept values, the metadata and a last-of-row flag. The activation stream carries four activations. A beat is consumed only when both streams present data together. After the beat marked last, the unit enters a one-cycle result state. In that cycle it raises `done_o`, shows the row total and the row's metadata error flag, and accepts nothing. It then returns to accepting with a cleared accumulator.

The control is a two-state machine. `S_RUN` accepts beats. The transition `S_RUN -> S_DONE` is taken when a beat with the last flag is consumed; otherwise `S_RUN -> S_RUN`. `S_DONE -> S_RUN` is taken unconditionally after one cycle.

Top module: `sp24_dot`

## Requirements
- R1: After reset, `done_o` is 0, `result_o` is 0 and `err_o` is 0, and the unit is in `S_RUN`.
- R2: Every consumed beat adds w0*act[idx0] + w1*act[idx1] to the row sum. All values are two's complement 8-bit. Weight slot k is `w_data[8k+7:8k]` and activation lane i is `a_data[8i+7:8i]`. An explicit zero weight contributes nothing.
- R3: The metadata encoding is idx0 = `w_meta[1:0]` (paired with slot 0) and idx1 = `w_meta[3:2]` (paired with slot 1). All six legal position pairs select correctly.
- R4: A beat is consumed only when both valids are high in `S_RUN`. `w_ready` equals (`S_RUN` and `a_valid`), and `a_ready` equals (`S_RUN` and `w_valid`).
- R5: `done_o` is high for exactly the one cycle after the beat carrying `w_last`.
- R6: Each row starts from a zero sum, so an identical row gives an identical result.
- R7: While `done_o` is high, both readies are low and no beat is consumed.
- R8: A group whose first index is not strictly below its second is in error. It contributes zero, and `err_o` is 1 alongside that row's result. A row without such a group shows `err_o` = 0.
- R9: `result_o` and `err_o` change only in the cycle after a last beat and hold otherwise.
- R10: The sum is 32-bit signed and exact for extreme operands, e.g. (-128)*(-128) in both slots gives 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| w_valid | input | 1 | Compressed weight beat valid |
| w_ready | output | 1 | Weight beat accepted when high with w_valid |
| w_data | input | 16 | Two kept signed weights, slot 0 in the low byte |
| w_meta | input | 4 | Two 2-bit positions, slot 0 index in bits 1:0 |
| w_last | input | 1 | Beat is the final group of the row |
| a_valid | input | 1 | Activation beat valid |
| a_ready | output | 1 | Activation beat accepted when high with a_valid |
| a_data | input | 32 | Four signed activations, lane 0 in the low byte |
| done_o | output | 1 | One-cycle pulse: row result is valid |
| result_o | output | 32 | Signed row dot product, held until the next row ends |
| err_o | output | 1 | Row contained a group with invalid metadata |

## Verification
On every cycle, the embedded assertions check four things. The result pulse lasts one cycle and follows a last beat. The readies stay low during the result state. The result and error outputs hold between rows. A consumption happens only with both valids present.

Only the bench scenarios can show that the arithmetic is right. It compares each row sum against a dense dot product built by expanding the compressed groups with zeros. Those scenarios cover every legal index pair, invalid index orders, signed extremes, staggered valids on the two streams and back-to-back rows.

// File: rtl/sp24_pkg.sv
package sp24_pkg;
    typedef enum logic [0:0] {
        S_RUN  = 1'b0,
        S_DONE = 1'b1
    } sp24_state_t;
endpackage

// File: rtl/sp24_select.sv
module sp24_select #(
    parameter int DW    = 8,
    parameter int LANES = 4,
    localparam int IW   = $clog2(LANES)
) (
    input  logic [LANES*DW-1:0] act_flat,
    input  logic [IW-1:0]       idx,
    output logic [DW-1:0]       sel
);
    logic [DW-1:0] lane [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane[i] = act_flat[i*DW +: DW];
    end

    assign sel = lane[idx];
endmodule

// File: rtl/sp24_mac.sv
module sp24_mac #(
    parameter int DW   = 8,
    parameter int AW   = 32,
    parameter int KEEP = 2,
    localparam int PW  = 2*DW
) (
    input  logic [KEEP*DW-1:0] w_flat,
    input  logic [KEEP*DW-1:0] a_flat,
    input  logic               en,
    output logic [AW-1:0]      sum_o
);
    logic [AW-1:0] ext [KEEP];

    for (genvar k = 0; k < KEEP; k++) begin : g_mul
        logic signed [DW-1:0] wv;
        logic signed [DW-1:0] av;
        logic signed [PW-1:0] pv;
        assign wv     = w_flat[k*DW +: DW];
        assign av     = a_flat[k*DW +: DW];
        assign pv     = wv * av;
        assign ext[k] = {{(AW-PW){pv[PW-1]}}, pv};
    end

    always_comb begin
        sum_o = '0;
        if (en) begin
            for (int k = 0; k < KEEP; k++) begin
                sum_o = sum_o + ext[k];
            end
        end
    end
endmodule

// File: rtl/sp24_ctrl.sv
module sp24_ctrl
    import sp24_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic w_valid,
    input  logic a_valid,
    input  logic last,
    output logic w_ready,
    output logic a_ready,
    output logic fire,
    output logic done
);
    sp24_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:  state_d = (fire && last) ? S_DONE : S_RUN;
            S_DONE: state_d = S_RUN;
            default: state_d = S_RUN;
        endcase
    end

    always_comb begin
        w_ready = 1'b0;
        a_ready = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            S_RUN: begin
                w_ready = a_valid;
                a_ready = w_valid;
            end
            S_DONE: done = 1'b1;
            default: done = 1'b0;
        endcase
        fire = w_ready && w_valid;
    end

    AST_FIRE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (w_valid && a_valid)); // R4
endmodule

// File: rtl/sp24_dot.sv
module sp24_dot #(
    parameter int DW    = 8,
    parameter int AW    = 32,
    parameter int LANES = 4,
    parameter int KEEP  = 2,
    localparam int IW   = $clog2(LANES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 w_valid,
    output logic                 w_ready,
    input  logic [KEEP*DW-1:0]   w_data,
    input  logic [KEEP*IW-1:0]   w_meta,
    input  logic                 w_last,
    input  logic                 a_valid,
    output logic                 a_ready,
    input  logic [LANES*DW-1:0]  a_data,
    output logic                 done_o,
    output logic [AW-1:0]        result_o,
    output logic                 err_o
);
    logic              fire;
    logic [KEEP*DW-1:0] picked;
    logic [AW-1:0]     grp_sum;
    logic [AW-1:0]     acc_q;
    logic              row_err_q;
    logic [KEEP-1:0]   order_ok;
    logic              grp_err;

    sp24_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .w_valid (w_valid),
        .a_valid (a_valid),
        .last    (w_last),
        .w_ready (w_ready),
        .a_ready (a_ready),
        .fire    (fire),
        .done    (done_o)
    );

    for (genvar k = 0; k < KEEP; k++) begin : g_slot
        sp24_select #(.DW(DW), .LANES(LANES)) u_sel (
            .act_flat (a_data),
            .idx      (w_meta[k*IW +: IW]),
            .sel      (picked[k*DW +: DW])
        );
        if (k == 0) begin : g_first
            assign order_ok[k] = 1'b1;
        end else begin : g_rest
            assign order_ok[k] = w_meta[(k-1)*IW +: IW] < w_meta[k*IW +: IW];
        end
    end

    assign grp_err = ~&order_ok;

    sp24_mac #(.DW(DW), .AW(AW), .KEEP(KEEP)) u_mac (
        .w_flat (w_data),
        .a_flat (picked),
        .en     (!grp_err),
        .sum_o  (grp_sum)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            row_err_q <= 1'b0;
            result_o  <= '0;
            err_o     <= 1'b0;
        end else if (fire) begin
            if (w_last) begin
                result_o  <= acc_q + grp_sum;
                err_o     <= row_err_q | grp_err;
                acc_q     <= '0;
                row_err_q <= 1'b0;
            end else begin
                acc_q     <= acc_q + grp_sum;
                row_err_q <= row_err_q | grp_err;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && w_last) |=> done_o); // R5
    AST_NO_ACCEPT_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!w_ready && !a_ready)); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire && w_last) |=> ($stable(result_o) && $stable(err_o))); // R9
endmodule

// File: tb/sp24_dot_tb.sv
module sp24_dot_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        w_valid = 1'b0, a_valid = 1'b0, w_last = 1'b0;
    logic [15:0] w_data = '0;
    logic [3:0]  w_meta = '0;
    logic [31:0] a_data = '0;
    logic        w_ready, a_ready, done_o, err_o;
    logic [31:0] result_o;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    // behavioural reference state
    bit exp_run = 1'b1, exp_done = 1'b0, exp_err = 1'b0, row_err = 1'b0;
    int exp_acc = 0, exp_res = 0;

    always #5 clk = ~clk;

    sp24_dot u_dut (
        .clk(clk), .rst_n(rst_n),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
        .w_meta(w_meta), .w_last(w_last),
        .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
        .done_o(done_o), .result_o(result_o), .err_o(err_o)
    );

    function automatic int dense_dot(logic [15:0] wd, logic [3:0] m, logic [31:0] ad);
        int d[4];
        int s;
        for (int i = 0; i < 4; i++) d[i] = 0;
        if (m[1:0] < m[3:2]) begin
            d[m[1:0]] = int'($signed(wd[7:0]));
            d[m[3:2]] = int'($signed(wd[15:8]));
        end
        s = 0;
        for (int i = 0; i < 4; i++) s += d[i] * int'($signed(ad[8*i +: 8]));
        return s;
    endfunction

    always @(posedge clk) begin
        bit f;
        bit nd;
        if (!rst_n) begin
            exp_run = 1; exp_done = 0; exp_acc = 0; exp_res = 0;
            exp_err = 0; row_err = 0;
        end else begin
            f  = exp_run && w_valid && a_valid;
            nd = f && w_last;
            if (f) begin
                exp_acc += dense_dot(w_data, w_meta, a_data);
                row_err |= !(w_meta[1:0] < w_meta[3:2]);
                if (w_last) begin
                    exp_res = exp_acc; exp_err = row_err;
                    exp_acc = 0; row_err = 0;
                end
            end
            exp_done = nd;
            exp_run  = !nd;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (done_o !== exp_done) begin
                fails++;
                $display("FAIL R5 done_o act=%0b exp=%0b", done_o, exp_done);
            end
            if (w_ready !== (exp_run && a_valid) || a_ready !== (exp_run && w_valid)) begin
                fails++;
                $display("FAIL R4 R7 readies act=%0b%0b exp=%0b%0b", w_ready, a_ready,
                         exp_run && a_valid, exp_run && w_valid);
            end
            if ($signed(result_o) !== exp_res) begin
                fails++;
                $display("FAIL R2 R3 R6 R9 R10 result act=%0d exp=%0d",
                         $signed(result_o), exp_res);
            end
            if (err_o !== exp_err) begin
                fails++;
                $display("FAIL R8 err_o act=%0b exp=%0b", err_o, exp_err);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog act=%0d cycles exp=<100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic send(input logic [7:0] w0, input logic [7:0] w1,
                        input logic [1:0] i0, input logic [1:0] i1,
                        input bit last, input logic [31:0] acts,
                        input int wgap, input int agap);
        bit got;
        w_data = {w1, w0}; w_meta = {i1, i0}; w_last = last; a_data = acts;
        for (int c = 0; c < wgap + agap + 1; c++) begin
            w_valid = (c >= wgap);
            a_valid = (c >= agap);
            if (c < wgap + agap) begin
                @(posedge clk); #1;
            end
        end
        w_valid = 1; a_valid = 1;
        got = 0;
        while (!got) begin
            @(negedge clk);
            got = w_ready && w_valid;
            @(posedge clk); #1;
        end
        w_valid = 0; a_valid = 0; w_last = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state
        vectors++;
        if (done_o !== 0 || result_o !== 0 || err_o !== 0) begin
            fails++;
            $display("FAIL R1 reset act=%0b/%0d/%0b exp=0/0/0", done_o, result_o, err_o);
        end
        @(posedge clk); #1;
        // R2 R3: all six legal position pairs, one-group rows
        for (int a = 0; a < 4; a++)
            for (int b = a + 1; b < 4; b++)
                send(8'(3 + a), 8'(-5 - b), 2'(a), 2'(b), 1,
                     32'h11F3_7E02 + 32'(a * 16 + b), 0, 0);
        // R10: signed extremes
        send(8'h80, 8'h80, 2'd1, 2'd3, 1, 32'h8080_8080, 0, 0);
        send(8'h7F, 8'h80, 2'd0, 2'd2, 1, 32'h807F_807F, 1, 0);
        // R6: identical multi-group rows back to back
        for (int r = 0; r < 2; r++) begin
            send(8'd10, 8'd0, 2'd0, 2'd3, 0, 32'h0102_0304, 0, 0);
            send(8'hF6, 8'd7, 2'd1, 2'd2, 0, 32'hFF80_7F01, 0, 2);
            send(8'd1, 8'd2, 2'd2, 2'd3, 1, 32'h0505_0505, 3, 0);
        end
        // R8: invalid orders (equal, reversed), then a clean row
        send(8'd9, 8'd9, 2'd2, 2'd2, 0, 32'h0909_0909, 0, 0);
        send(8'd4, 8'd4, 2'd0, 2'd1, 1, 32'h0000_0203, 0, 0);
        send(8'd4, 8'd4, 2'd3, 2'd0, 1, 32'h0303_0303, 0, 0);
        send(8'd4, 8'd4, 2'd0, 2'd1, 1, 32'h0000_0203, 0, 0);
        // random rows, staggered valids
        for (int r = 0; r < 40; r++) begin
            int n;
            n = 1 + ($urandom % 6);
            for (int g = 0; g < n; g++) begin
                logic [1:0] x, y;
                x = 2'($urandom); y = 2'($urandom);
                if ($urandom % 8 != 0 && x >= y) begin
                    x = 2'($urandom % 3); y = 2'(x + 1 + ($urandom % (3 - x)));
                end
                send(8'($urandom), 8'($urandom), x, y, g == n - 1, $urandom,
                     $urandom % 3, $urandom % 3);
            end
        end
        repeat (4) @(posedge clk);
        #1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule